// File: doc/BRIEF.md
# Debug Cache RAM Index Reader

This block services a debug command that names one internal storage array, a way and an index, and copies the selected entry into a set of four 32-bit result words. Instruction-side arrays write their results to an instruction result set. Data-side and second-level arrays write theirs to a data result set. The block holds small parameterised stand-in arrays: first-level instruction tag, first-level instruction data, branch-target, first-level data tag, second-level tag and second-level dirty. A backdoor write port loads these arrays.

Every read is filtered by the privilege of the caller. A non-secure caller at EL1 or EL2 sees an entry only when that entry is marked valid and non-secure. Such a caller always reads the branch-target array as zero. Secure EL1, secure EL2 and EL3 callers see raw contents. A way number beyond the last way of an array reads the last way, so way 3 of a three-way array reads way 2. The following are rejected with an error flag and zeroed results: a reserved array code, non-zero reserved bits, and a command from EL0.

Top module: `dbg_ram_reader`

## Requirements
- R1: The command word carries the array code in bits [31:24], reserved bits in [23:22], the way in [21:18] and the index in [17:0]. The row used is the index modulo ROWS, so index bits above the row width have no effect.
- R2: The accepted array codes are 0x00 instruction tag, 0x01 instruction data, 0x02 branch-target, 0x08 data tag, 0x10 L2 tag and 0x14 L2 dirty. Any other code, or a non-zero value in bits [23:22], sets `err` and clears all eight result words.
- R3: A command issued with `cur_el` equal to 0 sets `err` and clears all eight result words. A command from EL1, EL2 or EL3 completes with `err` low.
- R4: After reset, all result words, `done` and `err` are 0. A strobe accepted in cycle n gives a one-cycle `done` in cycle n+2. The result words and `err` change only in that cycle.
- R5: A strobe during the two cycles after an accepted strobe is ignored. It does not change the results and produces no extra `done`.
- R6: For a caller with `cur_ns`=1 and `cur_el` of 1 or 2, an entry that is not both valid and non-secure writes zeros to its destination set.
- R7: A caller at EL3, or with `cur_ns`=0, receives the packed contents whatever the entry's valid and non-secure markings are.
- R8: The branch-target array (0x02) always reads as zero for a non-secure EL1 or EL2 caller.
- R9: A way field greater than or equal to an array's way count reads that array's last way. Way 3 on the three-way instruction arrays reads way 2.
- R10: An instruction tag read gives word1 = {30'b0, valid, ns} and word0 = payload[31:0].
- R11: An instruction data or branch-target read gives word1 = payload[63:32] and word0 = payload[31:0].
- R12: A data tag read gives word1[1:0] = payload[31:30] (state 00 invalid, 01 exclusive, 10 shared, 11 modified), word0[30] = ns and word0[29:0] = payload[29:0].
- R13: An L2 tag read gives word0 = {ns, payload[28:0], payload[30:29]}, with state 00 invalid, 01 exclusive/modified and 11 shared/owned. An L2 dirty read gives word0[7:4] = payload[4:1] and word0[0] = payload[0] (the dirty bit).
- R14: Codes 0x00 to 0x02 write only the instruction set (`i_regs`). The other codes write only the data set (`d_regs`). The set that is not selected keeps its value, and words the array does not use read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe |
| cmd_word | input | 32 | Command word (array code, way, index) |
| cur_el | input | 2 | Exception level of the caller |
| cur_ns | input | 1 | Caller is in non-secure state |
| bd_we | input | 1 | Backdoor array write enable |
| bd_ram | input | 8 | Backdoor target array code |
| bd_way | input | 4 | Backdoor way |
| bd_row | input | ROW_W | Backdoor row |
| bd_valid | input | 1 | Valid marking to store |
| bd_ns | input | 1 | Non-secure marking to store |
| bd_payload | input | 64 | Entry payload to store |
| i_regs | output | 128 | Instruction result set, word k in bits [32k+31:32k] |
| d_regs | output | 128 | Data result set, word k in bits [32k+31:32k] |
| done | output | 1 | Completion pulse |
| err | output | 1 | Last command was rejected |

## Verification
The command is captured at the clock edge that samples the strobe. The selected entry is packed and registered at the next edge. `done`, `err` and both result sets are therefore first visible in the second cycle after the strobe cycle. The bench drives the strobe on a falling edge and checks that `done` is still low one falling edge later. It then compares `done`, `err` and both result sets against its own model at the falling edge after that. It waits one more cycle before the next strobe so that the busy window cannot swallow a command by accident.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

  localparam logic [7:0] CODE_ITAG    = 8'h00;
  localparam logic [7:0] CODE_IDATA   = 8'h01;
  localparam logic [7:0] CODE_BTB     = 8'h02;
  localparam logic [7:0] CODE_DTAG    = 8'h08;
  localparam logic [7:0] CODE_L2TAG   = 8'h10;
  localparam logic [7:0] CODE_L2DIRTY = 8'h14;

  localparam int N_ARR = 6;

  typedef enum logic [2:0] {
    ARR_ITAG    = 3'd0,
    ARR_IDATA   = 3'd1,
    ARR_BTB     = 3'd2,
    ARR_DTAG    = 3'd3,
    ARR_L2TAG   = 3'd4,
    ARR_L2DIRTY = 3'd5,
    ARR_NONE    = 3'd6
  } arr_e;

  typedef struct packed {
    logic        valid;
    logic        ns;
    logic [63:0] payload;
  } entry_t;

  function automatic arr_e code_to_arr(logic [7:0] code);
    arr_e a;
    case (code)
      CODE_ITAG:    a = ARR_ITAG;
      CODE_IDATA:   a = ARR_IDATA;
      CODE_BTB:     a = ARR_BTB;
      CODE_DTAG:    a = ARR_DTAG;
      CODE_L2TAG:   a = ARR_L2TAG;
      CODE_L2DIRTY: a = ARR_L2DIRTY;
      default:      a = ARR_NONE;
    endcase
    return a;
  endfunction

  function automatic logic arr_is_iside(arr_e a);
    return (a == ARR_ITAG) || (a == ARR_IDATA) || (a == ARR_BTB);
  endfunction

  // Ways past the end of an array fold onto its last way.
  function automatic logic [3:0] clamp_way(logic [3:0] way, int nways);
    if (int'(way) >= nways) return 4'(nways - 1);
    return way;
  endfunction

  function automatic logic caller_restricted(logic [1:0] el, logic ns);
    return ns && ((el == 2'd1) || (el == 2'd2));
  endfunction

  function automatic logic [127:0] pack_entry(arr_e a, entry_t e);
    logic [31:0] w0;
    logic [31:0] w1;
    w0 = '0;
    w1 = '0;
    case (a)
      ARR_ITAG: begin
        w1 = {30'd0, e.valid, e.ns};
        w0 = e.payload[31:0];
      end
      ARR_IDATA, ARR_BTB: begin
        w1 = e.payload[63:32];
        w0 = e.payload[31:0];
      end
      ARR_DTAG: begin
        w1 = {30'd0, e.payload[31:30]};
        w0 = {1'b0, e.ns, e.payload[29:0]};
      end
      ARR_L2TAG:   w0 = {e.ns, e.payload[28:0], e.payload[30:29]};
      ARR_L2DIRTY: w0 = {24'd0, e.payload[4:1], 3'd0, e.payload[0]};
      default: ;
    endcase
    return {64'd0, w1, w0};
  endfunction

endpackage

// File: rtl/dbgrd_cmd_decode.sv
module dbgrd_cmd_decode
  import dbgrd_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic [31:0]      cmd_word,
  input  logic [1:0]       cur_el,
  output arr_e             arr,
  output logic [3:0]       way,
  output logic [ROW_W-1:0] row,
  output logic             bad
);

  logic unused_idx_hi;

  always_comb begin
    arr = code_to_arr(cmd_word[31:24]);
    way = cmd_word[21:18];
    row = cmd_word[ROW_W-1:0];
    bad = (arr == ARR_NONE) || (cmd_word[23:22] != 2'b00) || (cur_el == 2'd0);
  end

  assign unused_idx_hi = ^cmd_word[17:ROW_W];

endmodule

// File: rtl/dbgrd_store.sv
module dbgrd_store
  import dbgrd_pkg::*;
#(
  parameter int NWAYS = 3,
  parameter int ROWS  = 16,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_way,
  input  logic [ROW_W-1:0] wr_row,
  input  entry_t           wr_entry,
  input  logic [3:0]       rd_way,
  input  logic [ROW_W-1:0] rd_row,
  output entry_t           rd_entry
);

  localparam int DEPTH = NWAYS * ROWS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t mem [DEPTH];

  function automatic logic [AW-1:0] slot(logic [3:0] way, logic [ROW_W-1:0] r);
    return AW'(int'(clamp_way(way, NWAYS)) * ROWS + int'(r));
  endfunction

  logic [AW-1:0] wr_slot;
  logic [AW-1:0] rd_slot;

  assign wr_slot = slot(wr_way, wr_row);
  assign rd_slot = slot(rd_way, rd_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_slot] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_slot];

  // R9: a folded way never addresses outside the array
  always_comb begin
    assert (int'(rd_slot) < DEPTH) else $error("assert_slot_in_range_R9");
  end

endmodule

// File: rtl/dbgrd_pack.sv
module dbgrd_pack
  import dbgrd_pkg::*;
(
  input  arr_e         arr,
  input  logic         bad,
  input  logic         restricted,
  input  entry_t       entry,
  output logic [127:0] word,
  output logic         to_i,
  output logic         to_d,
  output logic         blocked
);

  always_comb begin
    blocked = restricted && ((arr == ARR_BTB) || !(entry.valid && entry.ns));
    to_i    = bad || arr_is_iside(arr);
    to_d    = bad || !arr_is_iside(arr);
    if (bad || blocked) word = '0;
    else                word = pack_entry(arr, entry);
  end

endmodule

// File: rtl/dbg_ram_reader.sv
module dbg_ram_reader
  import dbgrd_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int I_WAYS  = 3,
  parameter int D_WAYS  = 4,
  parameter int L2_WAYS = 8,
  parameter int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [31:0]      cmd_word,
  input  logic [1:0]       cur_el,
  input  logic             cur_ns,
  input  logic             bd_we,
  input  logic [7:0]       bd_ram,
  input  logic [3:0]       bd_way,
  input  logic [ROW_W-1:0] bd_row,
  input  logic             bd_valid,
  input  logic             bd_ns,
  input  logic [63:0]      bd_payload,
  output logic [127:0]     i_regs,
  output logic [127:0]     d_regs,
  output logic             done,
  output logic             err
);

  // decode of the incoming command
  arr_e             dec_arr;
  logic [3:0]       dec_way;
  logic [ROW_W-1:0] dec_row;
  logic             dec_bad;

  dbgrd_cmd_decode #(.ROW_W(ROW_W)) u_dec (
    .cmd_word (cmd_word),
    .cur_el   (cur_el),
    .arr      (dec_arr),
    .way      (dec_way),
    .row      (dec_row),
    .bad      (dec_bad)
  );

  // capture stage
  logic             s1_v;
  arr_e             s1_arr;
  logic [3:0]       s1_way;
  logic [ROW_W-1:0] s1_row;
  logic             s1_bad;
  logic             s1_restr;
  logic             done_q;
  logic             busy;
  logic             accept;

  assign busy   = s1_v || done_q;
  assign accept = cmd_stb && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_arr   <= ARR_NONE;
      s1_way   <= '0;
      s1_row   <= '0;
      s1_bad   <= 1'b0;
      s1_restr <= 1'b0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_arr   <= dec_arr;
        s1_way   <= dec_way;
        s1_row   <= dec_row;
        s1_bad   <= dec_bad;
        s1_restr <= caller_restricted(cur_el, cur_ns);
      end
    end
  end

  // stand-in arrays
  entry_t rd_e [N_ARR];
  entry_t bd_entry;
  arr_e   bd_arr;

  assign bd_entry = '{valid: bd_valid, ns: bd_ns, payload: bd_payload};
  assign bd_arr   = code_to_arr(bd_ram);

  for (genvar g = 0; g < N_ARR; g++) begin : g_arr
    localparam int NW = (g < 3) ? I_WAYS : ((g == 3) ? D_WAYS : L2_WAYS);
    logic wr_hit;
    assign wr_hit = bd_we && (bd_arr == arr_e'(g));
    dbgrd_store #(.NWAYS(NW), .ROWS(ROWS), .ROW_W(ROW_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit),
      .wr_way   (bd_way),
      .wr_row   (bd_row),
      .wr_entry (bd_entry),
      .rd_way   (s1_way),
      .rd_row   (s1_row),
      .rd_entry (rd_e[g])
    );
  end

  entry_t sel_entry;
  always_comb begin
    sel_entry = '0;
    for (int g = 0; g < N_ARR; g++) begin
      if (s1_arr == arr_e'(g)) sel_entry = rd_e[g];
    end
  end

  // packing and privilege filter
  logic [127:0] pk_word;
  logic         pk_to_i;
  logic         pk_to_d;
  logic         pk_blocked;

  dbgrd_pack u_pack (
    .arr        (s1_arr),
    .bad        (s1_bad),
    .restricted (s1_restr),
    .entry      (sel_entry),
    .word       (pk_word),
    .to_i       (pk_to_i),
    .to_d       (pk_to_d),
    .blocked    (pk_blocked)
  );

  // result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_regs <= '0;
      d_regs <= '0;
      err    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= s1_v;
      if (s1_v) begin
        err <= s1_bad;
        if (pk_to_i) i_regs <= pk_word;
        if (pk_to_d) d_regs <= pk_word;
      end
    end
  end

  assign done = done_q;

  // assertions
  assert_done_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> done_q);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_results_move_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(i_regs) && $stable(d_regs) && $stable(err)) |-> done_q);
  assert_stage_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s1_v, done_q}));
  assert_busy_ignores_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && busy) |=> !s1_v);
  assert_reject_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_bad) |=> (err && (i_regs == '0) && (d_regs == '0)));
  assert_btb_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_bad && s1_restr && (s1_arr == ARR_BTB)) |=> (i_regs == '0));
  assert_blocked_iside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_bad && pk_blocked && arr_is_iside(s1_arr)) |=> (i_regs == '0));
  assert_blocked_dside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_bad && pk_blocked && !arr_is_iside(s1_arr)) |=> (d_regs == '0));
  assert_other_set_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_bad && arr_is_iside(s1_arr)) |=> $stable(d_regs));

endmodule

// File: tb/dbg_ram_reader_bench.sv
module dbg_ram_reader_bench;

  localparam int ROWS  = 16;
  localparam int ROW_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stb = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0] cur_el = 2'd3;
  logic cur_ns = 1'b0;
  logic bd_we = 1'b0;
  logic [7:0] bd_ram = '0;
  logic [3:0] bd_way = '0;
  logic [ROW_W-1:0] bd_row = '0;
  logic bd_valid = 1'b0;
  logic bd_ns = 1'b0;
  logic [63:0] bd_payload = '0;
  logic [127:0] i_regs;
  logic [127:0] d_regs;
  logic done;
  logic err;

  dbg_ram_reader u_dbg_ram_reader (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_word(cmd_word),
    .cur_el(cur_el), .cur_ns(cur_ns), .bd_we(bd_we), .bd_ram(bd_ram),
    .bd_way(bd_way), .bd_row(bd_row), .bd_valid(bd_valid), .bd_ns(bd_ns),
    .bd_payload(bd_payload), .i_regs(i_regs), .d_regs(d_regs),
    .done(done), .err(err)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog R4: actual cycles %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // bench model: slot [array][way][row] = {valid, ns, payload}
  logic [65:0] mdl [6][8][16];
  logic [127:0] exp_i = '0;
  logic [127:0] exp_d = '0;
  logic exp_err = 1'b0;

  function automatic logic [7:0] code_of(int a);
    logic [7:0] c [6] = '{8'h00, 8'h01, 8'h02, 8'h08, 8'h10, 8'h14};
    return c[a];
  endfunction

  function automatic int ways_of(int a);
    if (a < 3) return 3;
    if (a == 3) return 4;
    return 8;
  endfunction

  function automatic logic [63:0] fill_pl(int a, int w, int r);
    return {32'(a * 32'h01010101 + w * 32'h100 + r * 7),
            32'(32'hC3A50000 + a * 4096 + w * 256 + r * 17)};
  endfunction

  function automatic logic [127:0] exp_pack(int a, logic [65:0] e);
    logic [127:0] v = '0;
    logic [63:0] p = e[63:0];
    case (a)
      0: begin v[63:32] = 32'(e[65]) * 2 + 32'(e[64]); v[31:0] = p[31:0]; end
      1, 2: v[63:0] = p;
      3: begin v[33:32] = p[31:30]; v[30] = e[64]; v[29:0] = p[29:0]; end
      4: begin v[31] = e[64]; v[30:2] = p[28:0]; v[1:0] = p[30:29]; end
      default: begin v[7:4] = p[4:1]; v[0] = p[0]; end
    endcase
    return v;
  endfunction

  task automatic check(string tag, logic ok, logic [127:0] act, logic [127:0] expv);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic run_op(logic [31:0] cw, logic [1:0] el, logic ns, string tag);
    logic d1;
    @(negedge clk);
    cmd_word = cw; cur_el = el; cur_ns = ns; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
    d1 = done;
    @(negedge clk);
    check({tag, "/R4 done"}, (d1 == 1'b0) && (done == 1'b1), {126'd0, d1, done}, 128'd1);
    check({tag, " i_regs"}, i_regs == exp_i, i_regs, exp_i);
    check({tag, " d_regs"}, d_regs == exp_d, d_regs, exp_d);
    check({tag, " err"}, err == exp_err, {127'd0, err}, {127'd0, exp_err});
  endtask

  function automatic logic [31:0] mk_cmd(logic [7:0] code, logic [1:0] rsv, int w, int idx);
    return {code, rsv, 4'(w), 18'(idx)};
  endfunction

  // model of a successful read
  task automatic model_read(int a, int w, int r, logic [1:0] el, logic ns);
    int aw;
    logic restr;
    logic [65:0] e;
    logic [127:0] v;
    aw = (w >= ways_of(a)) ? ways_of(a) - 1 : w;
    e = mdl[a][aw][r];
    restr = ns && (el == 2'd1 || el == 2'd2);
    if (restr && (a == 2 || !(e[65] && e[64]))) v = '0;
    else v = exp_pack(a, e);
    if (a < 3) exp_i = v; else exp_d = v;
    exp_err = 1'b0;
  endtask

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset", (i_regs == '0) && (d_regs == '0) && !done && !err,
          i_regs | d_regs | {126'd0, done, err}, 128'd0);

    // load every entry of every array through the backdoor
    for (int a = 0; a < 6; a++) begin
      for (int w = 0; w < ways_of(a); w++) begin
        for (int r = 0; r < ROWS; r++) begin
          @(negedge clk);
          bd_we = 1'b1; bd_ram = code_of(a); bd_way = 4'(w); bd_row = ROW_W'(r);
          bd_valid = ((r % 3) != 0); bd_ns = (((w + r) % 2) == 1);
          bd_payload = fill_pl(a, w, r);
          mdl[a][w][r] = {bd_valid, bd_ns, bd_payload};
        end
      end
    end
    @(negedge clk);
    bd_we = 1'b0;

    // sweep: four caller contexts, every array, every way plus one past, every row
    for (int c = 0; c < 4; c++) begin
      logic [1:0] el;
      logic ns;
      el = (c == 0) ? 2'd3 : ((c == 3) ? 2'd1 : 2'(c));
      ns = (c == 1) || (c == 2);
      for (int a = 0; a < 6; a++) begin
        for (int w = 0; w <= ways_of(a); w++) begin
          for (int r = 0; r < ROWS; r++) begin
            string pt;
            string vt;
            pt = (a == 0) ? "R10" : (a < 3) ? "R11" : (a == 3) ? "R12" : "R13";
            vt = !ns ? "R7" : ((a == 2) ? "R8" : "R6");
            tag = $sformatf("R1/%s/%s/R14%s/R3", pt, vt, (w >= ways_of(a)) ? "/R9" : "");
            model_read(a, w, r, el, ns);
            run_op(mk_cmd(code_of(a), 2'b00, w, r + ROWS * (w * 3 + 1)), el, ns, tag);
          end
        end
      end
    end

    // R9 directed: way 3 of the three-way instruction data array equals way 2
    model_read(1, 2, 5, 2'd3, 1'b0);
    run_op(mk_cmd(8'h01, 2'b00, 3, 5), 2'd3, 1'b0, "R9 alias way3");
    check("R9 way3 reads way2 payload", i_regs[63:0] == mdl[1][2][5][63:0],
          i_regs, {64'd0, mdl[1][2][5][63:0]});

    // R14: a data-side read leaves the instruction set in place
    model_read(4, 1, 2, 2'd3, 1'b0);
    run_op(mk_cmd(8'h10, 2'b00, 1, 2), 2'd3, 1'b0, "R14 dside");
    check("R14 iset held", i_regs[63:0] == mdl[1][2][5][63:0],
          i_regs, {64'd0, mdl[1][2][5][63:0]});

    // R2: reserved code and reserved bits
    exp_i = '0; exp_d = '0; exp_err = 1'b1;
    run_op(mk_cmd(8'h03, 2'b00, 0, 1), 2'd3, 1'b0, "R2 reserved code");
    model_read(3, 0, 4, 2'd3, 1'b0);
    run_op(mk_cmd(8'h08, 2'b00, 0, 4), 2'd3, 1'b0, "R2 recover");
    exp_i = '0; exp_d = '0; exp_err = 1'b1;
    run_op(mk_cmd(8'h08, 2'b01, 0, 4), 2'd3, 1'b0, "R2 reserved bits");

    // R3: EL0 is rejected
    model_read(0, 1, 4, 2'd1, 1'b0);
    run_op(mk_cmd(8'h00, 2'b00, 1, 4), 2'd1, 1'b0, "R3 EL1 ok");
    exp_i = '0; exp_d = '0; exp_err = 1'b1;
    run_op(mk_cmd(8'h00, 2'b00, 1, 4), 2'd0, 1'b0, "R3 EL0 rejected");

    // R5: strobe held through the busy window with a different command
    model_read(5, 3, 7, 2'd3, 1'b0);
    @(negedge clk);
    cmd_word = mk_cmd(8'h14, 2'b00, 3, 7); cur_el = 2'd3; cur_ns = 1'b0; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_word = mk_cmd(8'h00, 2'b00, 0, 1);
    @(negedge clk);
    check("R5 first result", (d_regs == exp_d) && done, d_regs, exp_d);
    @(negedge clk);
    cmd_stb = 1'b0;
    check("R5 no second done", !done && (i_regs == exp_i), i_regs, exp_i);
    @(negedge clk);
    check("R5 still idle", !done && (i_regs == exp_i) && (d_regs == exp_d), i_regs, exp_i);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule